// File: doc/BRIEF.md
# Alert Pulse Width Classifier

The classifier sits beside a memory controller and watches the active-low alert line that the memory devices share. Two kinds of fault pull this line low: a failed check on write data and a parity fault on the command/address bus. The line level cannot tell them apart, so the block measures how many interface clock cycles each low pulse lasts and sorts the pulse by that length alone.

A short pulse is taken as a write-data check error. A long pulse is taken as a command/address parity error. Every other length is reported as an unrecognised alert. A line held low beyond the longest legal parity pulse is flagged as stuck while it is still low. Each result gives a one-cycle strobe, sets sticky flags and, for the two real fault classes, advances a saturating event counter. Host software clears flags with a masked clear write.

The pulse measurer is a three-state machine. In `ST_IDLE` the line is high. `IDLE_TO_LOW` starts a count of 1 at the first synchronized low sample. In `ST_LOW` the count grows by one for each further low sample. `LOW_TO_IDLE` fires on the first high sample and classifies the count. `LOW_TO_STUCK` fires when a low sample arrives with the count already at its ceiling. In `ST_STUCK` the machine waits, and `STUCK_TO_IDLE` fires on the first high sample and reports an unrecognised alert.

Top module: `alert_width_classifier`

## Requirements
- R1: The alert input passes through a two-flop synchronizer. Pulse length is the number of consecutive synchronized low samples, so an input held low for N clock cycles measures N.
- R2: A length from 6 to 10 inclusive emits one `crc_evt_o` strobe, sets `flags_o[0]` (check-error flag) and `flags_o[1]` (check-error status), and adds one to `crc_cnt_o`.
- R3: A length from 48 to 144 inclusive emits one `par_evt_o` strobe, sets `flags_o[2]` and adds one to `par_cnt_o`.
- R4: Lengths 1–5, 11–47 and anything above 144 emit `unk_evt_o`, set `flags_o[3]` and leave both counters unchanged.
- R5: When the line is still low on its 145th synchronized sample, `flags_o[4]` (stuck low) is set before the line returns high. The rising edge then reports an unrecognised alert.
- R6: Each strobe lasts one cycle and appears in the cycle after the rising edge is sampled. At most one strobe is high at a time.
- R7: A cycle with `clr_wr_i` high clears each flag whose bit in `clr_mask_i` is 1 (bit i clears `flags_o[i]`). Other flags keep their values.
- R8: When a flag's set event and a clear of the same flag fall in the same cycle, the flag stays set.
- R9: Both counters saturate at all ones and hold there.
- R10: Reset clears all flags, counters and strobes.
- R11: The check-error flag and the check-error status bit are separate and can each be cleared without the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alert_n_i | input | 1 | Shared active-low alert line |
| clr_wr_i | input | 1 | Clear write strobe |
| clr_mask_i | input | 5 | Flags to clear, one bit per flag |
| crc_evt_o | output | 1 | One-cycle strobe for a write-data check error |
| par_evt_o | output | 1 | One-cycle strobe for a command/address parity error |
| unk_evt_o | output | 1 | One-cycle strobe for an unrecognised pulse |
| flags_o | output | 5 | Sticky flags: [0] check error, [1] check status, [2] parity, [3] unknown, [4] stuck low |
| crc_cnt_o | output | CNT_W | Saturating count of check-error events |
| par_cnt_o | output | CNT_W | Saturating count of parity events |

## Verification
The assertions assume that the alert line changes no faster than the synchronizer can follow. They also assume that a clear write is a plain level sampled on the clock, with no relation to any pulse other than the same-cycle collision named in R8. The stimulus drives the alert line and the clear inputs only on falling clock edges and holds every level for whole cycles. Between pulses it leaves the line high long enough for each strobe, flag and counter update to settle. The collision case is the one exception: the clear is placed on the edge where the strobe is applied to the flags.

// File: rtl/awc_pkg.sv
package awc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_STUCK = 2'd2
    } awc_state_e;

    localparam int FLG_CRC     = 0;
    localparam int FLG_CRC_STS = 1;
    localparam int FLG_PAR     = 2;
    localparam int FLG_UNK     = 3;
    localparam int FLG_STUCK   = 4;
    localparam int NFLAG       = 5;
endpackage

// File: rtl/awc_sync.sv
module awc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/awc_measure.sv
module awc_measure
    import awc_pkg::*;
#(
    parameter int CRC_MIN = 6,
    parameter int CRC_MAX = 10,
    parameter int PAR_MIN = 48,
    parameter int PAR_MAX = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_s_i,
    output logic crc_evt_o,
    output logic par_evt_o,
    output logic unk_evt_o,
    output logic stuck_evt_o
);
    localparam int LEN_W = $clog2(PAR_MAX + 1);

    awc_state_e        state_q, state_d;
    logic [LEN_W-1:0]  len_q, len_d;
    logic              crc_d, par_d, unk_d, stuck_d;

    // state register and length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
        end
    end

    // transitions and classification
    always_comb begin
        state_d = state_q;
        len_d   = len_q;
        crc_d   = 1'b0;
        par_d   = 1'b0;
        unk_d   = 1'b0;
        stuck_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!alert_s_i) begin            // IDLE_TO_LOW
                    state_d = ST_LOW;
                    len_d   = LEN_W'(1);
                end
            end
            ST_LOW: begin
                if (alert_s_i) begin             // LOW_TO_IDLE
                    state_d = ST_IDLE;
                    len_d   = '0;
                    if (len_q >= LEN_W'(CRC_MIN) && len_q <= LEN_W'(CRC_MAX))
                        crc_d = 1'b1;
                    else if (len_q >= LEN_W'(PAR_MIN) && len_q <= LEN_W'(PAR_MAX))
                        par_d = 1'b1;
                    else
                        unk_d = 1'b1;
                end else if (len_q == LEN_W'(PAR_MAX)) begin // LOW_TO_STUCK
                    state_d = ST_STUCK;
                    stuck_d = 1'b1;
                end else begin
                    len_d = len_q + 1'b1;
                end
            end
            ST_STUCK: begin
                if (alert_s_i) begin             // STUCK_TO_IDLE
                    state_d = ST_IDLE;
                    len_d   = '0;
                    unk_d   = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                len_d   = '0;
            end
        endcase
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_evt_o   <= 1'b0;
            par_evt_o   <= 1'b0;
            unk_evt_o   <= 1'b0;
            stuck_evt_o <= 1'b0;
        end else begin
            crc_evt_o   <= crc_d;
            par_evt_o   <= par_d;
            unk_evt_o   <= unk_d;
            stuck_evt_o <= stuck_d;
        end
    end

    assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crc_evt_o, par_evt_o, unk_evt_o, stuck_evt_o}));

    assert_crc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_evt_o |=> !crc_evt_o);

    assert_par_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        par_evt_o |=> !par_evt_o);

    assert_stuck_leaves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_evt_o |-> state_q == ST_STUCK);

    assert_strobe_after_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_evt_o || par_evt_o || unk_evt_o) |-> $past(alert_s_i));
endmodule

// File: rtl/awc_status.sv
module awc_status
    import awc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crc_evt_i,
    input  logic             par_evt_i,
    input  logic             unk_evt_i,
    input  logic             stuck_evt_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [CNT_W-1:0] crc_cnt_o,
    output logic [CNT_W-1:0] par_cnt_o
);
    localparam int NCNT = 2;

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NCNT-1:0]  inc_v;
    logic [CNT_W-1:0] cnt_q [NCNT];

    always_comb begin
        set_v              = '0;
        set_v[FLG_CRC]     = crc_evt_i;
        set_v[FLG_CRC_STS] = crc_evt_i;
        set_v[FLG_PAR]     = par_evt_i;
        set_v[FLG_UNK]     = unk_evt_i;
        set_v[FLG_STUCK]   = stuck_evt_i;
        clr_v              = clr_wr_i ? clr_mask_i : '0;
        inc_v              = {par_evt_i, crc_evt_i};
    end

    // sticky flags: set has priority over clear
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_o[g] <= 1'b0;
            else if (set_v[g]) flags_o[g] <= 1'b1;
            else if (clr_v[g]) flags_o[g] <= 1'b0;
        end
    end

    // saturating event counters
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cnt_q[c] <= '0;
            else if (inc_v[c] && cnt_q[c] != '1) cnt_q[c] <= cnt_q[c] + 1'b1;
        end
    end

    assign crc_cnt_o = cnt_q[0];
    assign par_cnt_o = cnt_q[1];

    assert_crc_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        crc_evt_i |=> flags_o[FLG_CRC] && flags_o[FLG_CRC_STS]);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_evt_i && clr_wr_i && clr_mask_i[FLG_PAR]) |=> flags_o[FLG_PAR]);

    assert_clear_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_mask_i[FLG_UNK] && !unk_evt_i) |=> !flags_o[FLG_UNK]);

    assert_unknown_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unk_evt_i |=> $stable(crc_cnt_o) && $stable(par_cnt_o));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_cnt_o == '1) |=> (crc_cnt_o == '1));

    assert_par_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_evt_i && par_cnt_o != '1) |=> par_cnt_o == $past(par_cnt_o) + 1'b1);
endmodule

// File: rtl/alert_width_classifier.sv
module alert_width_classifier
    import awc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CRC_MIN = 6,
    parameter int CRC_MAX = 10,
    parameter int PAR_MIN = 48,
    parameter int PAR_MAX = 144
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alert_n_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic             crc_evt_o,
    output logic             par_evt_o,
    output logic             unk_evt_o,
    output logic [NFLAG-1:0] flags_o,
    output logic [CNT_W-1:0] crc_cnt_o,
    output logic [CNT_W-1:0] par_cnt_o
);
    logic alert_s;
    logic stuck_evt;

    awc_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (alert_n_i),
        .q_o   (alert_s)
    );

    awc_measure #(
        .CRC_MIN (CRC_MIN),
        .CRC_MAX (CRC_MAX),
        .PAR_MIN (PAR_MIN),
        .PAR_MAX (PAR_MAX)
    ) u_measure (
        .clk         (clk),
        .rst_n       (rst_n),
        .alert_s_i   (alert_s),
        .crc_evt_o   (crc_evt_o),
        .par_evt_o   (par_evt_o),
        .unk_evt_o   (unk_evt_o),
        .stuck_evt_o (stuck_evt)
    );

    awc_status #(.CNT_W(CNT_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .crc_evt_i   (crc_evt_o),
        .par_evt_i   (par_evt_o),
        .unk_evt_i   (unk_evt_o),
        .stuck_evt_i (stuck_evt),
        .clr_wr_i    (clr_wr_i),
        .clr_mask_i  (clr_mask_i),
        .flags_o     (flags_o),
        .crc_cnt_o   (crc_cnt_o),
        .par_cnt_o   (par_cnt_o)
    );

    assert_reset_clear_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> (flags_o == '0 && crc_cnt_o == '0 && par_cnt_o == '0));
endmodule

// File: tb/test_alert_width_classifier.sv
module test_alert_width_classifier;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alert_n = 1'b1;
    logic          clr_wr = 1'b0;
    logic [4:0]    clr_mask = '0;
    logic          crc_evt, par_evt, unk_evt;
    logic [4:0]    flags;
    logic [CW-1:0] crc_cnt, par_cnt;

    int n_vec = 0;
    int n_bad = 0;
    int s_crc = 0, s_par = 0, s_unk = 0, s_overlap = 0, s_long = 0;
    int e_crc = 0, e_par = 0, e_unk = 0;
    logic prev_crc = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alert_width_classifier #(.CNT_W(CW)) i_alert_width_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .alert_n_i  (alert_n),
        .clr_wr_i   (clr_wr),
        .clr_mask_i (clr_mask),
        .crc_evt_o  (crc_evt),
        .par_evt_o  (par_evt),
        .unk_evt_o  (unk_evt),
        .flags_o    (flags),
        .crc_cnt_o  (crc_cnt),
        .par_cnt_o  (par_cnt)
    );

    // strobe monitor
    always @(posedge clk) begin
        if (rst_n) begin
            s_crc += int'(crc_evt);
            s_par += int'(par_evt);
            s_unk += int'(unk_evt);
            if (int'(crc_evt) + int'(par_evt) + int'(unk_evt) > 1) s_overlap++;
            if (crc_evt && prev_crc) s_long++;
        end
        prev_crc <= crc_evt;
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        @(negedge clk) alert_n = 1'b0;
        repeat (n) @(negedge clk);
        alert_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic clear(input logic [4:0] m);
        @(negedge clk);
        clr_wr = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_wr = 1'b0;
        clr_mask = '0;
    endtask

    task automatic t_reset;
        check("R10 flags after reset", flags, 0);
        check("R10 crc count after reset", crc_cnt, 0);
        check("R10 par count after reset", par_cnt, 0);
    endtask

    task automatic t_crc_window;
        pulse(6);  e_crc++;
        check("R2 crc count len 6", crc_cnt, 1);
        check("R2 crc flag+status", flags & 5'b00011, 3);
        pulse(10); e_crc++;
        check("R2 crc count len 10", crc_cnt, 2);
        pulse(5);  e_unk++;
        check("R1 len 5 not crc", crc_cnt, 2);
        check("R4 len 5 unknown flag", flags[3], 1);
        pulse(11); e_unk++;
        check("R4 len 11 not crc", crc_cnt, 2);
        clear(5'b11111);
        check("R7 clear all", flags, 0);
    endtask

    task automatic t_par_window;
        pulse(48);  e_par++;
        check("R3 par count len 48", par_cnt, 1);
        check("R3 par flag", flags[2], 1);
        pulse(144); e_par++;
        check("R3 par count len 144", par_cnt, 2);
        check("R3 no unknown in window", flags[3], 0);
        pulse(47);  e_unk++;
        check("R4 len 47 no par count", par_cnt, 2);
        check("R4 len 47 unknown", flags[3], 1);
        clear(5'b11111);
    endtask

    task automatic t_stuck;
        @(negedge clk) alert_n = 1'b0;
        repeat (155) @(negedge clk);
        check("R5 line still low", alert_n, 0);
        check("R5 stuck flag while low", flags[4], 1);
        check("R5 no unknown yet", flags[3], 0);
        alert_n = 1'b1;
        repeat (8) @(negedge clk); e_unk++;
        check("R5 unknown after release", flags[3], 1);
        check("R5 par count unchanged", par_cnt, 2);
        clear(5'b11111);
        pulse(145); e_unk++;
        check("R5 len 145 stuck", flags[4], 1);
        check("R5 len 145 not par", par_cnt, 2);
        clear(5'b11111);
    endtask

    task automatic t_selective_clear;
        pulse(8); e_crc++;
        clear(5'b00001);
        check("R11 flag cleared", flags[0], 0);
        check("R11 status kept", flags[1], 1);
        pulse(20); e_unk++;
        clear(5'b00010);
        check("R11 status cleared", flags[1], 0);
        check("R7 unknown untouched", flags[3], 1);
        clear(5'b01000);
        check("R7 unknown cleared", flags, 0);
    endtask

    task automatic t_collide;
        pulse(7); e_crc++;
        @(negedge clk) alert_n = 1'b0;
        repeat (7) @(negedge clk);
        alert_n = 1'b1;
        @(posedge crc_evt); e_crc++;
        @(negedge clk);
        clr_wr = 1'b1;
        clr_mask = 5'b00001;
        @(negedge clk);
        clr_wr = 1'b0;
        clr_mask = '0;
        repeat (4) @(negedge clk);
        check("R8 set wins over clear", flags[0], 1);
        clear(5'b11111);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 6; i++) begin
            pulse(9); e_crc++;
        end
        check("R9 crc count saturated", crc_cnt, 7);
        pulse(100); e_par++;
        pulse(100); e_par++;
        pulse(100); e_par++;
        pulse(100); e_par++;
        pulse(100); e_par++;
        pulse(100); e_par++;
        check("R9 par count saturated", par_cnt, 7);
    endtask

    task automatic t_strobes;
        check("R6 crc strobes", s_crc, e_crc);
        check("R6 par strobes", s_par, e_par);
        check("R6 unknown strobes", s_unk, e_unk);
        check("R6 overlapping strobes", s_overlap, 0);
        check("R6 multi-cycle strobe", s_long, 0);
    endtask

    task automatic t_reset_again;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears flags", flags, 0);
        check("R10 reset clears crc count", crc_cnt, 0);
        check("R10 reset clears par count", par_cnt, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_crc_window;
        t_par_window;
        t_stuck;
        t_selective_clear;
        t_collide;
        t_saturate;
        t_strobes;
        t_reset_again;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule